// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block turns the architectural register names of a group of up to four instructions into physical register names in a single cycle. Each slot that writes a register takes the next physical register from a free list. Each source reads either the speculative map table or, when an earlier slot in the same group writes that architectural register, the fresh physical name of the nearest such earlier slot. The same architectural register may be renamed several times within one group. Every destination also reports the physical register it displaces, so that the retire logic can hand that register back later.

The physical register file holds 96 entries for 32 architectural registers, which leaves 64 for speculative results. The free list is a FIFO of physical register numbers. A second copy of the map tracks the retired state. On retirement the displaced physical register is appended to the free list and the retired map is updated. A flush copies the retired map into the speculative map. It returns every allocated but unretired register to the front of the free list, in allocation order. A group whose destinations outnumber the free registers is stalled as a whole.

Top module: `rn_rename_group`

## Requirements
- R1: Each accepted slot with `ren_valid` and `ren_has_dst` set receives on `ren_dst_phys` the next free-list entry, taken in ascending slot order. Slot 0 takes the head of the list.
- R2: A source reports the new physical register of the nearest lower-numbered valid slot in the same group that writes the same architectural register. When no such slot exists, it reports the speculative map entry.
- R3: Slots in one group that write the same architectural register receive distinct physical registers. After the group is accepted, the map holds the one from the highest-numbered of those slots.
- R4: `ren_old_phys` of a writing slot reports the mapping its destination had just before that slot: the nearest earlier in-group writer's new register, or else the map entry.
- R5: A slot without a destination, or with `ren_valid` low, takes no free-list entry and leaves the map unchanged.
- R6: `ren_ready` is low when the group needs more registers than the free list holds. In that case the whole group is dropped, with no map or free-list change.
- R7: Each retiring slot with `ret_valid` set appends its `ret_old_phys` to the free-list tail, in ascending slot order. It also sets the retired map entry of `ret_arch` to `ret_new_phys`, with the highest slot winning.
- R8: While `flush` is high, `ren_ready` is low. On the next cycle the speculative map equals the retired map. The free list then holds the unretired registers first, in allocation order, followed by the previously free entries.
- R9: After reset, architectural register n maps to physical n. The free list holds 32 to 95 in ascending order, and `ren_ready` is high.
- R10: With no retirement, exactly 64 destinations can be renamed from a full free list before renaming stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Restore speculative state from retired state |
| ren_valid | input | 4 | Slot holds an instruction |
| ren_has_dst | input | 4 | Slot writes a register |
| ren_src_a | input | 4x5 | First source architectural register per slot |
| ren_src_b | input | 4x5 | Second source architectural register per slot |
| ren_dst | input | 4x5 | Destination architectural register per slot |
| ren_ready | output | 1 | Group accepted this cycle |
| ren_src_a_phys | output | 4x7 | Physical name of first source |
| ren_src_b_phys | output | 4x7 | Physical name of second source |
| ren_dst_phys | output | 4x7 | Newly allocated physical destination |
| ren_old_phys | output | 4x7 | Physical register displaced by the destination |
| ret_valid | input | 4 | Retiring slot with a destination |
| ret_arch | input | 4x5 | Architectural destination of retiring slot |
| ret_new_phys | input | 4x7 | Physical register that becomes architectural |
| ret_old_phys | input | 4x7 | Physical register returned to the free list |

## Verification
Every cycle, the assertions check three things: registers given to one group are pairwise distinct, the free list never pops past its occupancy nor grows beyond 64, and the map stays unchanged on cycles that accept no writer. They also check that a flush leaves the speculative map equal to the retired map and refills the free count to 64. Only the bench scenarios can show the rest. That covers nearest-writer selection among several same-name writers, free-list order across retire and flush, the exact capacity of 64 before stalling, and the absence of effects from a stalled group. The bench shows these by comparing every output against an arithmetic model over long pseudo-random groups drawn from only eight architectural names.

// File: rtl/rename_pkg.sv
`timescale 1ns/1ps
// Shared sizes and types for the rename stage.
// Assumes PHYS_REGS - ARCH_REGS is a power of two (free-list ring).
package rename_pkg;
    parameter int unsigned GROUP      = 4;
    parameter int unsigned ARCH_REGS  = 32;
    parameter int unsigned PHYS_REGS  = 96;
    localparam int unsigned AW         = $clog2(ARCH_REGS);
    localparam int unsigned PW         = $clog2(PHYS_REGS);
    localparam int unsigned FREE_DEPTH = PHYS_REGS - ARCH_REGS;
    localparam int unsigned FPTR_W     = $clog2(FREE_DEPTH) + 1;
    localparam int unsigned CNT_W      = $clog2(GROUP + 1);
    typedef logic [AW-1:0] areg_t;
    typedef logic [PW-1:0] preg_t;
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
// Ring of free physical register numbers.
// head: next entry to hand out; tail: next slot to fill; chead: oldest
// entry handed out but not yet retired. Retirement is in allocation order,
// so each retire moves chead and tail together and tail-chead stays DEPTH.
// A flush rewinds head to chead, returning unretired entries in order.
// Assumes DEPTH is a power of two and callers never pop beyond free_cnt.
module rn_free_list import rename_pkg::*; #(
    parameter int unsigned DEPTH = FREE_DEPTH,
    parameter int unsigned LANES = GROUP,
    parameter int unsigned BASE  = ARCH_REGS,
    parameter int unsigned PTRW  = $clog2(DEPTH) + 1,
    parameter int unsigned CW    = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [CW-1:0]         pop_n,
    input  logic [LANES-1:0]      push_mask,
    input  preg_t [LANES-1:0]     push_phys,
    output preg_t [LANES-1:0]     peek,
    output logic [PTRW-1:0]       free_cnt
);
    localparam int unsigned IDXW = PTRW - 1;

    preg_t            mem [DEPTH];
    logic [PTRW-1:0]  head_q;
    logic [PTRW-1:0]  tail_q;
    logic [PTRW-1:0]  chead_q;
    logic [PTRW-1:0]  push_n;
    logic [PTRW-1:0]  push_off [LANES];

    function automatic logic [IDXW-1:0] slot(input logic [PTRW-1:0] p);
        return p[IDXW-1:0];
    endfunction

    // Prefix count of pushes gives each retiring lane its tail offset.
    always_comb begin
        push_n = '0;
        for (int k = 0; k < LANES; k++) begin
            push_off[k] = push_n;
            push_n      = push_n + PTRW'(push_mask[k]);
        end
    end

    // Expose the next LANES entries from the head.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            peek[k] = mem[slot(head_q + PTRW'(k))];
        end
    end

    assign free_cnt = tail_q - head_q;

    // Storage and pointer update: fill at tail, pop or rewind at head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                mem[j] <= preg_t'(BASE + j);
            end
            head_q  <= '0;
            tail_q  <= PTRW'(DEPTH);
            chead_q <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (push_mask[k]) begin
                    mem[slot(tail_q + push_off[k])] <= push_phys[k];
                end
            end
            tail_q  <= tail_q + push_n;
            chead_q <= chead_q + push_n;
            if (flush) begin
                head_q <= chead_q + push_n;
            end else begin
                head_q <= head_q + PTRW'(pop_n);
            end
        end
    end

    p_pop_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (PTRW'(pop_n) <= free_cnt));

    p_push_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, free_cnt} + {1'b0, push_n}) <= (PTRW + 1)'(DEPTH));

    p_flush_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_cnt == PTRW'(DEPTH)));
endmodule

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
// Speculative and retired architectural-to-physical maps.
// Speculative writes apply in ascending lane order (last lane wins); the
// same holds for retired writes. A flush loads the speculative map from
// the retired map including this cycle's retirements.
// Assumes the caller never raises spec_we together with flush.
module rn_map_table import rename_pkg::*; #(
    parameter int unsigned NARCH = ARCH_REGS,
    parameter int unsigned LANES = GROUP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [LANES-1:0]      spec_we,
    input  areg_t [LANES-1:0]     spec_arch,
    input  preg_t [LANES-1:0]     spec_phys,
    input  logic [LANES-1:0]      com_we,
    input  areg_t [LANES-1:0]     com_arch,
    input  preg_t [LANES-1:0]     com_phys,
    output preg_t [NARCH-1:0]     spec_map
);
    preg_t [NARCH-1:0] spec_q;
    preg_t [NARCH-1:0] spec_d;
    preg_t [NARCH-1:0] com_q;
    preg_t [NARCH-1:0] com_d;

    // Next retired map: apply retiring lanes in order.
    always_comb begin
        com_d = com_q;
        for (int k = 0; k < LANES; k++) begin
            if (com_we[k]) com_d[com_arch[k]] = com_phys[k];
        end
    end

    // Next speculative map: flush copy, then renamed lanes in order.
    always_comb begin
        spec_d = flush ? com_d : spec_q;
        for (int k = 0; k < LANES; k++) begin
            if (spec_we[k]) spec_d[spec_arch[k]] = spec_phys[k];
        end
    end

    // Register both maps; reset to the identity mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NARCH; j++) begin
                spec_q[j] <= preg_t'(j);
                com_q[j]  <= preg_t'(j);
            end
        end else begin
            spec_q <= spec_d;
            com_q  <= com_d;
        end
    end

    assign spec_map = spec_q;

    p_flush_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (spec_map == $past(com_d)));

    p_hold_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_we == '0 && !flush) |=> $stable(spec_map));
endmodule

// File: rtl/rn_group_bypass.sv
`timescale 1ns/1ps
// Combinational in-group renaming.
// Hands fresh registers to writing lanes in ascending order, and resolves
// sources and displaced mappings against the table, overridden by the
// nearest earlier writing lane of the same architectural register.
// Assumes fresh[] holds at least as many valid entries as writing lanes.
module rn_group_bypass import rename_pkg::*; #(
    parameter int unsigned LANES = GROUP,
    parameter int unsigned NARCH = ARCH_REGS,
    parameter int unsigned CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]      valid,
    input  logic [LANES-1:0]      has_dst,
    input  areg_t [LANES-1:0]     src_a,
    input  areg_t [LANES-1:0]     src_b,
    input  areg_t [LANES-1:0]     dst,
    input  preg_t [NARCH-1:0]     map,
    input  preg_t [LANES-1:0]     fresh,
    output preg_t [LANES-1:0]     src_a_phys,
    output preg_t [LANES-1:0]     src_b_phys,
    output preg_t [LANES-1:0]     dst_phys,
    output preg_t [LANES-1:0]     old_phys,
    output logic [LANES-1:0]      alloc,
    output logic [CW-1:0]         need
);
    // Allocation: each writing lane takes the next fresh register.
    always_comb begin
        int idx;
        idx   = 0;
        alloc = valid & has_dst;
        for (int i = 0; i < LANES; i++) begin
            dst_phys[i] = fresh[idx];
            if (alloc[i]) idx++;
        end
        need = CW'(idx);
    end

    // Lookup: table value, replaced by later (nearer) earlier-lane writers.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            src_a_phys[i] = map[src_a[i]];
            src_b_phys[i] = map[src_b[i]];
            old_phys[i]   = map[dst[i]];
            for (int j = 0; j < i; j++) begin
                if (alloc[j]) begin
                    if (dst[j] == src_a[i]) src_a_phys[i] = dst_phys[j];
                    if (dst[j] == src_b[i]) src_b_phys[i] = dst_phys[j];
                    if (dst[j] == dst[i])   old_phys[i]   = dst_phys[j];
                end
            end
        end
    end
endmodule

// File: rtl/rn_rename_group.sv
`timescale 1ns/1ps
// Four-wide rename stage top.
// Accepts a whole group when the free list covers its destinations and no
// flush is pending; otherwise drops it. Results are combinational in the
// cycle the group is presented; state updates at the clock edge.
// Assumes retirement follows allocation order and is not issued in the
// same cycle as a flush that must exclude it.
module rn_rename_group import rename_pkg::*; (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [GROUP-1:0]      ren_valid,
    input  logic [GROUP-1:0]      ren_has_dst,
    input  areg_t [GROUP-1:0]     ren_src_a,
    input  areg_t [GROUP-1:0]     ren_src_b,
    input  areg_t [GROUP-1:0]     ren_dst,
    output logic                  ren_ready,
    output preg_t [GROUP-1:0]     ren_src_a_phys,
    output preg_t [GROUP-1:0]     ren_src_b_phys,
    output preg_t [GROUP-1:0]     ren_dst_phys,
    output preg_t [GROUP-1:0]     ren_old_phys,
    input  logic [GROUP-1:0]      ret_valid,
    input  areg_t [GROUP-1:0]     ret_arch,
    input  preg_t [GROUP-1:0]     ret_new_phys,
    input  preg_t [GROUP-1:0]     ret_old_phys
);
    preg_t [ARCH_REGS-1:0] spec_map;
    preg_t [GROUP-1:0]     fresh;
    logic [FPTR_W-1:0]     free_cnt;
    logic [GROUP-1:0]      alloc;
    logic [GROUP-1:0]      spec_we;
    logic [CNT_W-1:0]      need;
    logic [CNT_W-1:0]      pop_n;

    rn_group_bypass #(.LANES(GROUP), .NARCH(ARCH_REGS)) u_bypass (
        .valid      (ren_valid),
        .has_dst    (ren_has_dst),
        .src_a      (ren_src_a),
        .src_b      (ren_src_b),
        .dst        (ren_dst),
        .map        (spec_map),
        .fresh      (fresh),
        .src_a_phys (ren_src_a_phys),
        .src_b_phys (ren_src_b_phys),
        .dst_phys   (ren_dst_phys),
        .old_phys   (ren_old_phys),
        .alloc      (alloc),
        .need       (need)
    );

    // Accept only when every destination can be served and no flush.
    assign ren_ready = !flush && (FPTR_W'(need) <= free_cnt);
    assign pop_n     = ren_ready ? need : '0;
    assign spec_we   = alloc & {GROUP{ren_ready}};

    rn_free_list #(.DEPTH(FREE_DEPTH), .LANES(GROUP), .BASE(ARCH_REGS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .pop_n     (pop_n),
        .push_mask (ret_valid),
        .push_phys (ret_old_phys),
        .peek      (fresh),
        .free_cnt  (free_cnt)
    );

    rn_map_table #(.NARCH(ARCH_REGS), .LANES(GROUP)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .spec_we   (spec_we),
        .spec_arch (ren_dst),
        .spec_phys (ren_dst_phys),
        .com_we    (ret_valid),
        .com_arch  (ret_arch),
        .com_phys  (ret_new_phys),
        .spec_map  (spec_map)
    );

    // R3: registers handed out in one group are pairwise distinct.
    for (genvar a = 0; a < GROUP; a++) begin : g_lane_a
        for (genvar b = a + 1; b < GROUP; b++) begin : g_lane_b
            p_distinct_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (spec_we[a] && spec_we[b]) |-> (ren_dst_phys[a] != ren_dst_phys[b]));
        end
    end
endmodule

// File: tb/test_rn_rename_group.sv
`timescale 1ns/1ps
// Self-checking bench: arithmetic model of maps, free list and in-flight list.
module test_rn_rename_group;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic [3:0]      ren_valid = '0;
    logic [3:0]      ren_has_dst = '0;
    logic [3:0][4:0] ren_src_a = '0;
    logic [3:0][4:0] ren_src_b = '0;
    logic [3:0][4:0] ren_dst = '0;
    logic            ren_ready;
    logic [3:0][6:0] ren_src_a_phys;
    logic [3:0][6:0] ren_src_b_phys;
    logic [3:0][6:0] ren_dst_phys;
    logic [3:0][6:0] ren_old_phys;
    logic [3:0]      ret_valid = '0;
    logic [3:0][4:0] ret_arch = '0;
    logic [3:0][6:0] ret_new_phys = '0;
    logic [3:0][6:0] ret_old_phys = '0;

    rn_rename_group i_rn_rename_group (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int smap [32];
    int cmap [32];
    int fq [$];
    int if_arch [$];
    int if_new [$];
    int if_old [$];
    int g_sa [4];
    int g_sb [4];
    int g_dd [4];
    bit last_ready;
    bit [31:0] rng = 32'h1badb002;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'(rng & 32'h7fffffff);
    endfunction

    // Present one group, compare outputs to the model, then update the model.
    task automatic run_group(input logic [3:0] v, input logic [3:0] hd,
                             input string stag, input string dtag);
        int need;
        int k;
        int ea;
        int eb;
        bit er;
        int newp [4];
        int oldp [4];
        @(negedge clk);
        flush = 1'b0;
        ret_valid = '0;
        ren_valid = v;
        ren_has_dst = hd;
        for (int i = 0; i < 4; i++) begin
            ren_src_a[i] = 5'(g_sa[i]);
            ren_src_b[i] = 5'(g_sb[i]);
            ren_dst[i]   = 5'(g_dd[i]);
        end
        #1;
        need = 0;
        for (int i = 0; i < 4; i++) if (v[i] && hd[i]) need++;
        er = (need <= fq.size());
        last_ready = ren_ready;
        check(ren_ready == er, "R6", int'(ren_ready), int'(er));
        k = 0;
        for (int i = 0; i < 4; i++) begin
            if (v[i] && hd[i] && er) begin
                newp[i] = fq[k];
                k++;
            end else begin
                newp[i] = -1;
            end
        end
        if (er) begin
            for (int i = 0; i < 4; i++) begin
                if (v[i]) begin
                    ea = smap[g_sa[i]];
                    eb = smap[g_sb[i]];
                    oldp[i] = smap[g_dd[i]];
                    for (int j = 0; j < i; j++) begin
                        if (v[j] && hd[j]) begin
                            if (g_dd[j] == g_sa[i]) ea = newp[j];
                            if (g_dd[j] == g_sb[i]) eb = newp[j];
                            if (g_dd[j] == g_dd[i]) oldp[i] = newp[j];
                        end
                    end
                    check(int'(ren_src_a_phys[i]) == ea, stag, int'(ren_src_a_phys[i]), ea);
                    check(int'(ren_src_b_phys[i]) == eb, stag, int'(ren_src_b_phys[i]), eb);
                    if (hd[i]) begin
                        check(int'(ren_dst_phys[i]) == newp[i], dtag, int'(ren_dst_phys[i]), newp[i]);
                        check(int'(ren_old_phys[i]) == oldp[i], "R4", int'(ren_old_phys[i]), oldp[i]);
                    end
                end
            end
        end
        @(posedge clk);
        if (er) begin
            for (int i = 0; i < 4; i++) begin
                if (v[i] && hd[i]) begin
                    void'(fq.pop_front());
                    smap[g_dd[i]] = newp[i];
                    if_arch.push_back(g_dd[i]);
                    if_new.push_back(newp[i]);
                    if_old.push_back(oldp[i]);
                end
            end
        end
    endtask

    // Read every architectural register through dst-less groups.
    task automatic lookup_all(input string tag);
        for (int grp = 0; grp < 8; grp++) begin
            for (int s = 0; s < 4; s++) begin
                g_sa[s] = grp * 4 + s;
                g_sb[s] = 31 - (grp * 4 + s);
                g_dd[s] = 0;
            end
            run_group(4'b1111, 4'b0000, tag, "R1");
        end
    endtask

    // Retire the k oldest in-flight destinations.
    task automatic do_retire(input int k);
        @(negedge clk);
        flush = 1'b0;
        ren_valid = '0;
        ret_valid = '0;
        for (int i = 0; i < k; i++) begin
            ret_valid[i]    = 1'b1;
            ret_arch[i]     = 5'(if_arch[i]);
            ret_new_phys[i] = 7'(if_new[i]);
            ret_old_phys[i] = 7'(if_old[i]);
        end
        @(posedge clk);
        for (int i = 0; i < k; i++) begin
            cmap[if_arch[0]] = if_new[0];
            fq.push_back(if_old[0]);
            void'(if_arch.pop_front());
            void'(if_new.pop_front());
            void'(if_old.pop_front());
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        ren_valid = 4'b1111;
        ren_has_dst = 4'b0000;
        ret_valid = '0;
        flush = 1'b1;
        #1;
        check(ren_ready == 1'b0, "R8", int'(ren_ready), 0);
        @(posedge clk);
        for (int a = 0; a < 32; a++) smap[a] = cmap[a];
        for (int i = if_new.size() - 1; i >= 0; i--) fq.push_front(if_new[i]);
        if_arch.delete();
        if_new.delete();
        if_old.delete();
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        for (int a = 0; a < 32; a++) begin
            smap[a] = a;
            cmap[a] = a;
        end
        for (int p = 32; p < 96; p++) fq.push_back(p);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ren_ready == 1'b1, "R9", int'(ren_ready), 1);

        // R9: identity map and first allocations 32..35.
        lookup_all("R9");
        for (int s = 0; s < 4; s++) begin
            g_sa[s] = s; g_sb[s] = s + 4; g_dd[s] = s + 8;
        end
        run_group(4'b1111, 4'b1111, "R9", "R9");

        // R2/R3: r1 renamed three times in one group, nearest writer wins.
        g_sa[0] = 1; g_sb[0] = 2; g_dd[0] = 1;
        g_sa[1] = 1; g_sb[1] = 3; g_dd[1] = 1;
        g_sa[2] = 1; g_sb[2] = 1; g_dd[2] = 2;
        g_sa[3] = 2; g_sb[3] = 1; g_dd[3] = 1;
        run_group(4'b1111, 4'b1111, "R2", "R3");
        lookup_all("R3");

        // R5: slots without destination or invalid consume nothing.
        for (int s = 0; s < 4; s++) begin
            g_sa[s] = s + 1; g_sb[s] = 5; g_dd[s] = 5 + s;
        end
        run_group(4'b1111, 4'b0101, "R2", "R5");
        run_group(4'b1011, 4'b1111, "R2", "R5");
        lookup_all("R5");

        // R10: from a full free list exactly 64 single-dst groups fit.
        do_flush();
        n = 0;
        for (int t = 0; t < 70; t++) begin
            g_sa[0] = (t + 3) % 32; g_sb[0] = t % 32; g_dd[0] = t % 32;
            run_group(4'b0001, 4'b0001, "R2", "R1");
            if (last_ready) n++;
            else break;
        end
        check(n == 64, "R10", n, 64);
        lookup_all("R6");

        // R6/R7: two retired registers serve two, not three, destinations.
        do_retire(2);
        for (int s = 0; s < 4; s++) begin
            g_sa[s] = s; g_sb[s] = s + 10; g_dd[s] = s + 20;
        end
        run_group(4'b0111, 4'b0111, "R2", "R1");
        check(last_ready == 1'b0, "R6", int'(last_ready), 0);
        run_group(4'b0011, 4'b0011, "R2", "R7");

        // R8: flush restores retired map and unretired registers first.
        do_retire(3);
        do_flush();
        lookup_all("R8");
        for (int s = 0; s < 4; s++) begin
            g_sa[s] = s; g_sb[s] = s; g_dd[s] = s + 12;
        end
        run_group(4'b1111, 4'b1111, "R8", "R8");

        // Sweep: pseudo-random groups over eight names with retire and flush.
        for (int it = 0; it < 1500; it++) begin
            logic [3:0] v;
            logic [3:0] hd;
            int r;
            if (it % 300 == 299) do_flush();
            r = next_rand();
            if ((r % 3) == 0 && if_new.size() > 0) begin
                do_retire(((r >> 4) % 4 + 1) > if_new.size() ? if_new.size() : ((r >> 4) % 4 + 1));
            end
            v  = 4'(next_rand());
            hd = 4'(next_rand());
            for (int s = 0; s < 4; s++) begin
                g_sa[s] = next_rand() % 8;
                g_sb[s] = next_rand() % 8;
                g_dd[s] = next_rand() % 8;
            end
            run_group(v, hd, "R2", "R1");
        end
        lookup_all("R3");
        finish_run();
    end
endmodule